// File: doc/BRIEF.md
# Endpoint-0 Control Request Responder

This block sits behind the serial engine of a full-speed USB device and looks at each 8-byte SETUP packet received on endpoint 0. From the request type and code it decides whether the hardware answers the request itself, whether firmware must be told about it, or whether the request is refused. It then drives the handshake the endpoint gives: ACK, NAK or STALL.

Requests that only touch state the hardware owns are answered locally and never raise the firmware flag. Configuration and interface changes are reported to firmware. Descriptor requests and all non-standard requests are forwarded to firmware for decoding. An optional hold mode keeps configuration and interface changes in NAK until firmware grants them through a small control register. Malformed feature and interface requests are refused with STALL, and the STALL stays in force until the next SETUP.

Top module: `ep0_req_responder`

## Requirements
- R1: `hs_code` uses 2'b00 for ACK, 2'b01 for NAK and 2'b10 for STALL, and reflects a SETUP one cycle after the `setup_valid` strobe. Standard requests (type bits 6:5 equal 0) with codes 0 (get status), 5 (set address), 8 (get configuration), 10 (get interface) and 12 (synch frame) give ACK with `fw_pending` low.
- R2: With hold mode clear, standard code 9 (set configuration), and code 11 (set interface) with alternate setting 0, give ACK at once and raise `fw_pending`.
- R3: Standard codes 6 (get descriptor) and 7 (set descriptor), and any request whose type bits 6:5 are non-zero, give ACK, raise `fw_pending`, and are never held in NAK.
- R4: With hold mode set, standard codes 9 and 11 (alternate setting 0) give NAK with `fw_pending` high until firmware sets the response-enable bit; from the cycle after that write they give ACK.
- R5: The control register holds hold mode at bit 2 and response-enable at bit 7; both are write-1-to-set, writing 0 clears neither, and the other read bits are 0. Hold mode is cleared only by reset.
- R6: A write of 1 to response-enable while no request is held has no effect; the bit reads back 0.
- R7: Standard code 11 with a non-zero alternate setting (the value field) gives STALL and leaves `fw_pending` low.
- R8: Standard codes 1 (clear feature) and 3 (set feature) with a feature selector (the value field) of 0 or 1 give ACK without `fw_pending`; any larger selector gives STALL.
- R9: Any other standard request code gives STALL with `fw_pending` low.
- R10: A STALL stays on `hs_code` through `xfer_done` pulses and register writes until the next SETUP.
- R11: An `xfer_done` pulse completes the held request: it clears `fw_pending`, the response-enable bit and any NAK hold. A new SETUP discards the pending state of the previous one, including response-enable.
- R12: The request outputs carry the fields of the most recent SETUP: byte 0 type, byte 1 code, bytes 2-3 value, 4-5 index, 6-7 length, each 16-bit field low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_valid | input | 1 | One-cycle strobe: a SETUP packet is on `setup_data` |
| setup_data | input | 64 | SETUP bytes, byte i at bits 8i+7..8i |
| xfer_done | input | 1 | One-cycle pulse: the control transfer's status stage has finished |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read data |
| hs_code | output | 2 | Handshake endpoint 0 gives |
| fw_pending | output | 1 | A request awaits firmware |
| req_type | output | 8 | Latched request type |
| req_code | output | 8 | Latched request code |
| req_value | output | 16 | Latched value field |
| req_index | output | 16 | Latched index field |
| req_length | output | 16 | Latched length field |

## Verification
The assertions take for granted that `setup_valid`, `xfer_done` and register writes are never asserted in the same cycle, since the serial engine delivers a SETUP and a status-stage completion at different times and firmware does not write while a packet arrives. The stimulus keeps to that by driving each event alone in its own cycle on the falling clock edge, sweeping request codes, feature selectors, alternate settings and request types with hold mode both clear and set.

// File: rtl/ep0_req_pkg.sv
// Package: shared types and request codes for the endpoint-0 responder.
// Assumes USB little-endian SETUP layout with the type byte first.
package ep0_req_pkg;

    localparam int SETUP_BYTES = 8;
    localparam int SETUP_W     = SETUP_BYTES * 8;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    typedef enum logic [1:0] {
        ACT_HW,
        ACT_REPORT,
        ACT_FORWARD,
        ACT_STALL
    } act_e;

    localparam logic [7:0] RQ_GET_STATUS  = 8'd0;
    localparam logic [7:0] RQ_CLR_FEATURE = 8'd1;
    localparam logic [7:0] RQ_SET_FEATURE = 8'd3;
    localparam logic [7:0] RQ_SET_ADDR    = 8'd5;
    localparam logic [7:0] RQ_GET_DESC    = 8'd6;
    localparam logic [7:0] RQ_SET_DESC    = 8'd7;
    localparam logic [7:0] RQ_GET_CONFIG  = 8'd8;
    localparam logic [7:0] RQ_SET_CONFIG  = 8'd9;
    localparam logic [7:0] RQ_GET_IFACE   = 8'd10;
    localparam logic [7:0] RQ_SET_IFACE   = 8'd11;
    localparam logic [7:0] RQ_SYNCH_FRAME = 8'd12;

    localparam logic [15:0] MAX_FEATURE_SEL = 16'd1;

    // Packed so that the raw 64-bit SETUP word casts straight onto it.
    typedef struct packed {
        logic [15:0] length;
        logic [15:0] index;
        logic [15:0] value;
        logic [7:0]  code;
        logic [7:0]  rtype;
    } setup_s;

endpackage

// File: rtl/ep0_setup_decode.sv
// Module: classifies one SETUP packet into an action for the responder.
// Assumes: purely combinational; the caller samples it on the SETUP strobe.
module ep0_setup_decode
    import ep0_req_pkg::*;
(
    input  setup_s pkt_i,
    output act_e   act_o,
    output logic   hold_cand_o
);

    logic is_std;
    assign is_std = (pkt_i.rtype[6:5] == 2'b00);

    // Purpose: map type, code and value onto an action and a hold candidate.
    always_comb begin
        act_o       = ACT_STALL;
        hold_cand_o = 1'b0;
        if (!is_std) begin
            act_o = ACT_FORWARD;
        end else begin
            unique case (pkt_i.code)
                RQ_GET_STATUS, RQ_SET_ADDR, RQ_GET_CONFIG,
                RQ_GET_IFACE, RQ_SYNCH_FRAME:
                    act_o = ACT_HW;
                RQ_CLR_FEATURE, RQ_SET_FEATURE:
                    act_o = (pkt_i.value <= MAX_FEATURE_SEL) ? ACT_HW : ACT_STALL;
                RQ_GET_DESC, RQ_SET_DESC:
                    act_o = ACT_FORWARD;
                RQ_SET_CONFIG: begin
                    act_o       = ACT_REPORT;
                    hold_cand_o = 1'b1;
                end
                RQ_SET_IFACE: begin
                    if (pkt_i.value == 16'd0) begin
                        act_o       = ACT_REPORT;
                        hold_cand_o = 1'b1;
                    end else begin
                        act_o = ACT_STALL;
                    end
                end
                default:
                    act_o = ACT_STALL;
            endcase
        end
    end

endmodule

// File: rtl/ep0_ctrl_reg.sv
// Module: control register holding hold mode and response-enable.
// Assumes: both bits write-1-to-set; response-enable only sets while a
// request is held and clears when the held request completes or a SETUP arrives.
module ep0_ctrl_reg #(
    parameter int REG_W    = 8,
    parameter int MODE_BIT = 2,
    parameter int RESP_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             held_i,
    input  logic             clr_resp_i,
    output logic             mode_o,
    output logic             resp_en_o,
    output logic [REG_W-1:0] rd_data_o
);

    logic mode_q;
    logic resp_q;
    logic set_mode;
    logic set_resp;

    assign set_mode = wr_en_i && wr_data_i[MODE_BIT];
    assign set_resp = wr_en_i && wr_data_i[RESP_BIT] && held_i && !clr_resp_i;

    // Purpose: sticky hold-mode bit, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= 1'b0;
        else if (set_mode) mode_q <= 1'b1;
    end

    // Purpose: response-enable grant for the currently held request.
    always_ff @(posedge clk) begin
        if (!rst_n)          resp_q <= 1'b0;
        else if (clr_resp_i) resp_q <= 1'b0;
        else if (set_resp)   resp_q <= 1'b1;
    end

    // Purpose: assemble read data with unused bits at zero.
    always_comb begin
        rd_data_o           = '0;
        rd_data_o[MODE_BIT] = mode_q;
        rd_data_o[RESP_BIT] = resp_q;
    end

    assign mode_o    = mode_q;
    assign resp_en_o = resp_q;

    // R5: hold mode never drops once set
    a_r5_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> mode_q);

    // R6: no grant appears while nothing is held
    a_r6_resp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_i && !resp_q) |=> !resp_q);

endmodule

// File: rtl/ep0_hs_engine.sv
// Module: per-SETUP state: stall, NAK hold, firmware flag and latched fields.
// Assumes: setup_valid and xfer_done are never high in the same cycle; if they
// are, the SETUP wins.
module ep0_hs_engine
    import ep0_req_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   setup_valid_i,
    input  setup_s pkt_i,
    input  act_e   act_i,
    input  logic   hold_cand_i,
    input  logic   mode_i,
    input  logic   resp_en_i,
    input  logic   xfer_done_i,
    output hs_e    hs_o,
    output logic   held_o,
    output logic   pending_o,
    output setup_s req_o
);

    logic   stall_q;
    logic   held_q;
    logic   pend_q;
    setup_s req_q;

    // Purpose: capture outcome of each SETUP and retire it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            held_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else if (setup_valid_i) begin
            stall_q <= (act_i == ACT_STALL);
            held_q  <= hold_cand_i && mode_i;
            pend_q  <= (act_i == ACT_REPORT) || (act_i == ACT_FORWARD);
        end else if (xfer_done_i) begin
            held_q  <= 1'b0;
            pend_q  <= 1'b0;
        end
    end

    // Purpose: latch request fields of every SETUP.
    always_ff @(posedge clk) begin
        if (!rst_n)             req_q <= '0;
        else if (setup_valid_i) req_q <= pkt_i;
    end

    // Purpose: select handshake from stall and hold state.
    always_comb begin
        if (stall_q)                   hs_o = HS_STALL;
        else if (held_q && !resp_en_i) hs_o = HS_NAK;
        else                           hs_o = HS_ACK;
    end

    assign held_o    = held_q;
    assign pending_o = pend_q;
    assign req_o     = req_q;

    // R10: a stall survives everything but a new SETUP
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o == HS_STALL && !setup_valid_i) |=> (hs_o == HS_STALL));

    // R7: a refused request never raises the firmware flag
    a_r7_stall_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o == HS_STALL) |-> !pend_q);

    // R11: completion retires the pending request
    a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && !setup_valid_i) |=> !pend_q);

endmodule

// File: rtl/ep0_req_responder.sv
// Module: top of the endpoint-0 control request responder.
// Assumes: SETUP bytes arrive in one cycle with a strobe; the status-stage
// completion pulse and register writes come in other cycles.
module ep0_req_responder
    import ep0_req_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int MODE_BIT = 2,
    parameter int RESP_BIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_valid,
    input  logic [SETUP_W-1:0] setup_data,
    input  logic               xfer_done,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wr_data,
    output logic [REG_W-1:0]   reg_rd_data,
    output logic [1:0]         hs_code,
    output logic               fw_pending,
    output logic [7:0]         req_type,
    output logic [7:0]         req_code,
    output logic [15:0]        req_value,
    output logic [15:0]        req_index,
    output logic [15:0]        req_length
);

    setup_s pkt;
    setup_s req;
    act_e   act;
    hs_e    hs;
    logic   hold_cand;
    logic   mode;
    logic   resp_en;
    logic   held;
    logic   clr_resp;

    assign pkt      = setup_s'(setup_data);
    assign clr_resp = setup_valid || xfer_done;

    ep0_setup_decode u_decode (
        .pkt_i       (pkt),
        .act_o       (act),
        .hold_cand_o (hold_cand)
    );

    ep0_ctrl_reg #(
        .REG_W    (REG_W),
        .MODE_BIT (MODE_BIT),
        .RESP_BIT (RESP_BIT)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .wr_data_i  (reg_wr_data),
        .held_i     (held),
        .clr_resp_i (clr_resp),
        .mode_o     (mode),
        .resp_en_o  (resp_en),
        .rd_data_o  (reg_rd_data)
    );

    ep0_hs_engine u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .setup_valid_i (setup_valid),
        .pkt_i         (pkt),
        .act_i         (act),
        .hold_cand_i   (hold_cand),
        .mode_i        (mode),
        .resp_en_i     (resp_en),
        .xfer_done_i   (xfer_done),
        .hs_o          (hs),
        .held_o        (held),
        .pending_o     (fw_pending),
        .req_o         (req)
    );

    assign hs_code    = hs;
    assign req_type   = req.rtype;
    assign req_code   = req.code;
    assign req_value  = req.value;
    assign req_index  = req.index;
    assign req_length = req.length;

    // R4: a NAK holds until a grant, a completion or a new SETUP
    a_r4_nak_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == 2'b01 && !setup_valid && !xfer_done
         && !(reg_wr_en && reg_wr_data[RESP_BIT])) |=> (hs_code == 2'b01));

    // R1: only the three defined handshake codes appear
    a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        hs_code != 2'b11);

    // R4: a NAK always comes with a request waiting on firmware
    a_r4_nak_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == 2'b01) |-> fw_pending);

endmodule

// File: tb/ep0_req_responder_tb.sv
module ep0_req_responder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [63:0] setup_data = '0;
    logic        xfer_done = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic [7:0]  reg_rd_data;
    logic [1:0]  hs_code;
    logic        fw_pending;
    logic [7:0]  req_type;
    logic [7:0]  req_code;
    logic [15:0] req_value;
    logic [15:0] req_index;
    logic [15:0] req_length;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] ACK = 2'b00, NAK = 2'b01, STL = 2'b10;

    always #2.5 clk = ~clk;

    ep0_req_responder u_dut (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_data(setup_data),
        .xfer_done(xfer_done), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .hs_code(hs_code), .fw_pending(fw_pending),
        .req_type(req_type), .req_code(req_code), .req_value(req_value),
        .req_index(req_index), .req_length(req_length)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v,
                        input logic [15:0] i, input logic [15:0] l);
        @(negedge clk);
        setup_valid = 1'b1;
        setup_data  = {l, i, v, c, t};
        @(negedge clk);
        setup_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic done();
        @(negedge clk) xfer_done = 1'b1;
        @(negedge clk) xfer_done = 1'b0;
    endtask

    // Expected {pending, handshake} of a SETUP, from the requirements.
    function automatic logic [2:0] expect_of(input logic [7:0] t, input logic [7:0] c,
                                            input logic [15:0] v, input bit mode);
        if (t[6:5] != 2'b00) return {1'b1, ACK};                    // R3
        case (c)
            8'd0, 8'd5, 8'd8, 8'd10, 8'd12: return {1'b0, ACK};     // R1
            8'd1, 8'd3: return (v <= 16'd1) ? {1'b0, ACK} : {1'b0, STL}; // R8
            8'd6, 8'd7: return {1'b1, ACK};                          // R3
            8'd9: return {1'b1, mode ? NAK : ACK};                   // R2/R4
            8'd11: return (v == 16'd0) ? {1'b1, mode ? NAK : ACK} : {1'b0, STL}; // R7
            default: return {1'b0, STL};                             // R9
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] e;
        do_reset();
        @(negedge clk);
        // R1/R5: reset state
        chk(hs_code == ACK, "R1 reset hs", hs_code, ACK);
        chk(fw_pending == 1'b0, "R1 reset pending", fw_pending, 0);
        chk(reg_rd_data == 8'h00, "R5 reset reg", reg_rd_data, 0);

        // Sweep codes 0..15 with hold mode clear, then set.
        for (int m = 0; m < 2; m++) begin
            do_reset();
            if (m == 1) begin
                wr(8'h04);
                chk(reg_rd_data == 8'h04, "R5 mode set", reg_rd_data, 8'h04);
                wr(8'h00);
                chk(reg_rd_data == 8'h04, "R5 zero write keeps", reg_rd_data, 8'h04);
            end
            for (int c = 0; c < 16; c++) begin
                e = expect_of(8'h00, 8'(c), 16'd0, m == 1);
                send(8'h00, 8'(c), 16'd0, 16'd0, 16'd0);
                chk(hs_code == e[1:0], "R1 R2 R3 R4 R9 sweep hs", hs_code, e[1:0]);
                chk(fw_pending == e[2], "R1 R2 R3 R9 sweep pending", fw_pending, e[2]);
                if (e[1:0] == NAK) begin
                    wr(8'h80);
                    chk(hs_code == ACK, "R4 grant gives ACK", hs_code, ACK);
                    chk(reg_rd_data == 8'h84, "R5 resp bit", reg_rd_data, 8'h84);
                    done();
                    chk(reg_rd_data == 8'h04, "R11 resp cleared", reg_rd_data, 8'h04);
                    chk(fw_pending == 1'b0, "R11 pending cleared", fw_pending, 0);
                    chk(hs_code == ACK, "R11 hold gone", hs_code, ACK);
                end else begin
                    wr(8'h80);
                    chk(reg_rd_data[7] == 1'b0, "R6 resp ignored", reg_rd_data, 0);
                    done();
                    chk(hs_code == e[1:0], "R10 hs after done", hs_code, e[1:0]);
                    chk(fw_pending == 1'b0, "R11 done clears", fw_pending, 0);
                end
            end
        end

        // Feature selectors and alternate settings, hold mode clear.
        do_reset();
        for (int v = 0; v < 5; v++) begin
            send(8'h00, 8'd1, 16'(v), 16'd0, 16'd0);
            e = expect_of(8'h00, 8'd1, 16'(v), 1'b0);
            chk(hs_code == e[1:0], "R8 clear feature", hs_code, e[1:0]);
            send(8'h02, 8'd3, 16'(v), 16'd0, 16'd0);
            e = expect_of(8'h02, 8'd3, 16'(v), 1'b0);
            chk(hs_code == e[1:0], "R8 set feature", hs_code, e[1:0]);
            chk(fw_pending == 1'b0, "R8 no pending", fw_pending, 0);
            send(8'h01, 8'd11, 16'(v), 16'd0, 16'd0);
            e = expect_of(8'h01, 8'd11, 16'(v), 1'b0);
            chk(hs_code == e[1:0], "R7 alt setting hs", hs_code, e[1:0]);
            chk(fw_pending == e[2], "R7 alt setting pending", fw_pending, e[2]);
        end
        send(8'h00, 8'd3, 16'h0100, 16'd0, 16'd0);
        chk(hs_code == STL, "R8 large selector", hs_code, STL);

        // R10: stall persists through writes and completion; cleared by SETUP.
        send(8'h00, 8'd2, 16'd0, 16'd0, 16'd0);
        wr(8'h80);
        done();
        repeat (3) @(negedge clk);
        chk(hs_code == STL, "R10 stall persists", hs_code, STL);
        send(8'h00, 8'd0, 16'd0, 16'd0, 16'd0);
        chk(hs_code == ACK, "R10 stall cleared by setup", hs_code, ACK);

        // R3: non-standard types forwarded, never held even in hold mode.
        wr(8'h04);
        for (int t = 1; t < 4; t++) begin
            send({1'b0, 2'(t), 5'd1}, 8'd9, 16'd0, 16'd0, 16'd0);
            chk(hs_code == ACK, "R3 nonstd hs", hs_code, ACK);
            chk(fw_pending == 1'b1, "R3 nonstd pending", fw_pending, 1);
        end

        // R11: new SETUP discards grant and pending state.
        send(8'h00, 8'd9, 16'd1, 16'd0, 16'd0);
        chk(hs_code == NAK, "R4 held", hs_code, NAK);
        wr(8'h80);
        chk(hs_code == ACK, "R4 granted", hs_code, ACK);
        send(8'h01, 8'd11, 16'd0, 16'd2, 16'd0);
        chk(hs_code == NAK, "R11 new setup drops grant", hs_code, NAK);
        chk(reg_rd_data == 8'h04, "R11 resp dropped", reg_rd_data, 8'h04);
        send(8'h80, 8'd0, 16'd0, 16'd0, 16'd2);
        chk(fw_pending == 1'b0, "R11 pending replaced", fw_pending, 0);
        chk(hs_code == ACK, "R1 get status", hs_code, ACK);

        // R12: field latching.
        send(8'h80, 8'd6, 16'h0201, 16'h0403, 16'h0605);
        chk(req_type == 8'h80, "R12 type", req_type, 8'h80);
        chk(req_code == 8'd6, "R12 code", req_code, 6);
        chk(req_value == 16'h0201, "R12 value", req_value, 16'h0201);
        chk(req_index == 16'h0403, "R12 index", req_index, 16'h0403);
        chk(req_length == 16'h0605, "R12 length", req_length, 16'h0605);
        done();
        chk(req_code == 8'd6, "R12 fields hold after done", req_code, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule